// File: doc/BRIEF.md
# Temporal-Spatial Colour Depth Reducer (8-bit to 6-bit FRC)

This block takes 24-bit RGB pixels (8 bits per channel) and prepares them for an 18-bit panel by keeping the upper six bits of each channel. It does not simply cut off the two bits it drops. It rounds some pixels up, so that the lost fraction shows up as an average over a 2x2 pixel group and over four consecutive frames. The pixel's parity position (row bit, column bit) selects an entry in a fixed four-entry threshold order. A frame phase that advances at every start of frame rotates that entry. Red, green and blue each add their own rotation offset so that their flicker patterns do not line up.

The block tracks position on its own from two markers that travel with each valid pixel: start of frame and start of line. Output channels stay 8 bits wide. While dithering is on, the two least significant bits are forced to zero. While it is off, pixels pass through unchanged. Each output is registered, so results appear one clock after the input pixel.

Top module: `frc_dither`

## Requirements
- R1: When `dith_en` is low with a valid pixel, each output channel equals the input channel bit for bit, one cycle later.
- R2: When `dith_en` is high with a valid pixel, bits [1:0] of every output channel are zero.
- R3: When dithering, output bits [7:2] equal input bits [7:2] or that value plus one. It never rises by more than one and never falls.
- R4: An input whose bits [7:2] are all ones (63) yields 63 in output bits [7:2], so a round-up saturates and does not wrap.
- R5: When dithering, an input whose bits [1:0] are zero is never rounded up.
- R6: The rounding rule works as follows. A pixel is rounded up exactly when its bits [1:0] exceed T[(P + F + K) mod 4]. T is the table {0,2,3,1} indexed 0..3. P = 2*row_parity + column_parity. F is the frame phase. K is 0 for red, 1 for green and 2 for blue.
- R7: A pixel at a fixed position, held over four consecutive frames with fraction f in bits [1:0], is rounded up exactly f times (f = 0..3).
- R8: Position and phase are tracked as follows. A valid pixel with `pix_sof` is at row 0, column 0 and advances F by one (F is 0 after reset). A valid pixel with `pix_sol`, and without `pix_sof`, toggles the row parity and sets column 0. Any other valid pixel toggles the column parity.
- R9: `pix_sof` and `pix_sol` have no effect while `pix_valid` is low.
- R10: `out_valid` is `pix_valid` delayed by one cycle. After reset, `out_valid` and all output channels are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dith_en | input | 1 | Dithering on (1) or pass-through (0), sampled with each pixel |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame (qualified by pix_valid) |
| pix_sol | input | 1 | First pixel of a line (qualified by pix_valid) |
| pix_r | input | 8 | Red input channel |
| pix_g | input | 8 | Green input channel |
| pix_b | input | 8 | Blue input channel |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 8 | Red output channel |
| out_g | output | 8 | Green output channel |
| out_b | output | 8 | Blue output channel |

## Verification
The checker looks at every clock for the pass-through identity, the zeroed low bits, the bounded round-up with saturation at full scale, the absence of rounding at zero fraction, and the one-cycle valid delay. These properties hold pixel by pixel. Whether the correct pixels are the ones rounded up depends on position, frame phase and the per-channel rotation, and the bench's scenarios are the only thing that shows this. It compares each output against a model that tracks rows, columns and frames, and counts round-ups over four frames. The same scenarios show that markers arriving without a valid pixel are ignored.

// File: rtl/frc_pkg.sv
// Package frc_pkg
// Shared constants and the ordered threshold table for the frame-rate dither.
// Assumes the dropped fraction is two bits wide, so the table has four entries.
package frc_pkg;
    localparam int IDX_W = 2;

    // Ordered thresholds: over the four indices each value 0..3 appears once.
    function automatic logic [IDX_W-1:0] frc_threshold(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] thr;
        case (idx)
            2'd0:    thr = 2'd0;
            2'd1:    thr = 2'd2;
            2'd2:    thr = 2'd3;
            default: thr = 2'd1;
        endcase
        return thr;
    endfunction
endpackage

// File: rtl/frc_position.sv
// Module frc_position
// Tracks the parity of the current pixel's row and column and the frame phase.
// Assumes sof/sol are qualified by pix_valid. Outputs describe the pixel
// presented in the current cycle (combinational from registered history).
module frc_position
    import frc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_sol,
    output logic [IDX_W-1:0] pos_idx,
    output logic [IDX_W-1:0] frame_ph
);
    logic             row_q;
    logic             col_q;
    logic [IDX_W-1:0] frm_q;
    logic             row_c;
    logic             col_c;

    // Position of the pixel in this cycle, derived from the last valid pixel.
    always_comb begin
        if (pix_sof) begin
            row_c = 1'b0;
            col_c = 1'b0;
        end else if (pix_sol) begin
            row_c = ~row_q;
            col_c = 1'b0;
        end else begin
            row_c = row_q;
            col_c = ~col_q;
        end
        frame_ph = (pix_valid && pix_sof) ? frm_q + 2'd1 : frm_q;
    end

    assign pos_idx = {row_c, col_c};

    // Remember position and frame phase of each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= 1'b0;
            col_q <= 1'b1;
            frm_q <= '0;
        end else if (pix_valid) begin
            row_q <= row_c;
            col_q <= col_c;
            frm_q <= frame_ph;
        end
    end
endmodule

// File: rtl/frc_channel.sv
// Module frc_channel
// Reduces one colour channel from CH_W to KEEP_W bits with threshold rounding.
// Assumes CH_W - KEEP_W == 2 (four-entry table). Purely combinational.
module frc_channel
    import frc_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int KEEP_W = 6,
    parameter int ROT    = 0
) (
    input  logic [CH_W-1:0]  pix_in,
    input  logic             enable,
    input  logic [IDX_W-1:0] pos_idx,
    input  logic [IDX_W-1:0] frame_ph,
    output logic [CH_W-1:0]  pix_out
);
    localparam int               DROP = CH_W - KEEP_W;
    localparam logic [IDX_W-1:0] ROT_V = IDX_W'(ROT);

    logic [KEEP_W-1:0] kept;
    logic [DROP-1:0]   frac;
    logic [IDX_W-1:0]  idx;
    logic              bump;

    // Decide round-up from fraction versus rotated threshold, saturating.
    always_comb begin
        kept = pix_in[CH_W-1:DROP];
        frac = pix_in[DROP-1:0];
        idx  = pos_idx + frame_ph + ROT_V;
        bump = (frac > frc_threshold(idx)) && (kept != {KEEP_W{1'b1}});
        if (enable)
            pix_out = {kept + KEEP_W'(bump), {DROP{1'b0}}};
        else
            pix_out = pix_in;
    end
endmodule

// File: rtl/frc_dither.sv
// Module frc_dither (top)
// Temporal-spatial dither of RGB from CH_W to KEEP_W bits per channel.
// Assumes markers accompany valid pixels; one register stage to the outputs.
module frc_dither
    import frc_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int KEEP_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dith_en,
    input  logic            pix_valid,
    input  logic            pix_sof,
    input  logic            pix_sol,
    input  logic [CH_W-1:0] pix_r,
    input  logic [CH_W-1:0] pix_g,
    input  logic [CH_W-1:0] pix_b,
    output logic            out_valid,
    output logic [CH_W-1:0] out_r,
    output logic [CH_W-1:0] out_g,
    output logic [CH_W-1:0] out_b
);
    localparam int NCH = 3;

    logic [IDX_W-1:0] pos_idx;
    logic [IDX_W-1:0] frame_ph;
    logic [CH_W-1:0]  in_ch  [NCH];
    logic [CH_W-1:0]  res_ch [NCH];
    logic [CH_W-1:0]  out_q  [NCH];

    assign in_ch[0] = pix_r;
    assign in_ch[1] = pix_g;
    assign in_ch[2] = pix_b;

    frc_position u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_valid(pix_valid),
        .pix_sof  (pix_sof),
        .pix_sol  (pix_sol),
        .pos_idx  (pos_idx),
        .frame_ph (frame_ph)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        frc_channel #(.CH_W(CH_W), .KEEP_W(KEEP_W), .ROT(c)) u_ch (
            .pix_in  (in_ch[c]),
            .enable  (dith_en),
            .pos_idx (pos_idx),
            .frame_ph(frame_ph),
            .pix_out (res_ch[c])
        );

        // Register each channel result when a pixel is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_q[c] <= '0;
            else if (pix_valid)
                out_q[c] <= res_ch[c];
        end
    end

    // Delay the pixel qualifier to match the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= pix_valid;
    end

    assign out_r = out_q[0];
    assign out_g = out_q[1];
    assign out_b = out_q[2];
endmodule

// File: rtl/frc_dither_chk.sv
// Module frc_dither_chk
// Per-cycle properties of frc_dither, attached by bind.
module frc_dither_chk #(
    parameter int CH_W   = 8,
    parameter int KEEP_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dith_en,
    input logic            pix_valid,
    input logic [CH_W-1:0] pix_r,
    input logic [CH_W-1:0] pix_g,
    input logic [CH_W-1:0] pix_b,
    input logic            out_valid,
    input logic [CH_W-1:0] out_r,
    input logic [CH_W-1:0] out_g,
    input logic [CH_W-1:0] out_b
);
    localparam int                DROP = CH_W - KEEP_W;
    localparam logic [KEEP_W-1:0] FULL = {KEEP_W{1'b1}};

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(pix_valid)); // R10

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_valid) && !$past(dith_en)) |->
        (out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b))); // R1

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_valid) && $past(dith_en)) |->
        (out_r[DROP-1:0] == '0 && out_g[DROP-1:0] == '0 && out_b[DROP-1:0] == '0)); // R2

    AST_STEP_RED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_valid) && $past(dith_en)) |->
        (out_r[CH_W-1:DROP] == $past(pix_r[CH_W-1:DROP]) ||
         out_r[CH_W-1:DROP] == $past(pix_r[CH_W-1:DROP]) + KEEP_W'(1))); // R3

    AST_STEP_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_valid) && $past(dith_en)) |->
        (out_g[CH_W-1:DROP] == $past(pix_g[CH_W-1:DROP]) ||
         out_g[CH_W-1:DROP] == $past(pix_g[CH_W-1:DROP]) + KEEP_W'(1))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_valid) && $past(dith_en) &&
         $past(pix_b[CH_W-1:DROP]) == FULL) |->
        out_b[CH_W-1:DROP] == FULL); // R4

    AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_valid) && $past(dith_en) &&
         $past(pix_r[DROP-1:0]) == '0) |->
        out_r == $past(pix_r)); // R5
endmodule

bind frc_dither frc_dither_chk #(.CH_W(CH_W), .KEEP_W(KEEP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dith_en  (dith_en),
    .pix_valid(pix_valid),
    .pix_r    (pix_r),
    .pix_g    (pix_g),
    .pix_b    (pix_b),
    .out_valid(out_valid),
    .out_r    (out_r),
    .out_g    (out_g),
    .out_b    (out_b)
);

// File: tb/test_frc_dither.sv
`timescale 1ns/1ps
module test_frc_dither;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dith_en = 1'b0;
    logic       pix_valid = 1'b0;
    logic       pix_sof = 1'b0;
    logic       pix_sol = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       out_valid;
    logic [7:0] out_r, out_g, out_b;

    int n_chk = 0;
    int n_bad = 0;
    logic       m_row = 1'b0, m_col = 1'b1;
    logic [1:0] m_frm = 2'd0;

    always #2.5 clk = ~clk;

    frc_dither i_frc_dither (
        .clk(clk), .rst_n(rst_n), .dith_en(dith_en), .pix_valid(pix_valid),
        .pix_sof(pix_sof), .pix_sol(pix_sol),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic logic [1:0] thr_of(input logic [1:0] i);
        case (i)
            2'd0: return 2'd0;
            2'd1: return 2'd2;
            2'd2: return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    // Expected channel value per R1..R6
    function automatic logic [7:0] exp_ch(input logic [7:0] v, input logic en,
                                          input logic [1:0] pos, input logic [1:0] ph,
                                          input logic [1:0] rot);
        logic [5:0] t;
        logic [1:0] i;
        if (!en) return v;
        t = v[7:2];
        i = pos + ph + rot;
        if (v[1:0] > thr_of(i) && t != 6'h3f) t = t + 6'd1;
        return {t, 2'b00};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; drives one cycle, checks at the next negedge.
    task automatic send(input logic v, input logic s, input logic l, input logic e,
                        input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                        input string req);
        logic [7:0] er, eg, eb;
        logic [1:0] pos;
        pix_valid = v; pix_sof = s; pix_sol = l; dith_en = e;
        pix_r = r; pix_g = g; pix_b = b;
        if (v) begin   // R8 position model, R9 markers ignored without valid
            if (s) begin m_frm = m_frm + 2'd1; m_row = 1'b0; m_col = 1'b0; end
            else if (l) begin m_row = ~m_row; m_col = 1'b0; end
            else m_col = ~m_col;
        end
        pos = {m_row, m_col};
        er = exp_ch(r, e, pos, m_frm, 2'd0);
        eg = exp_ch(g, e, pos, m_frm, 2'd1);
        eb = exp_ch(b, e, pos, m_frm, 2'd2);
        @(negedge clk);
        if (v)
            check(out_valid && out_r == er && out_g == eg && out_b == eb, req, "rgb/valid",
                  {7'd0, out_valid, out_r, out_g, out_b}, {8'd1, er, eg, eb});
        else
            check(!out_valid, "R10", "out_valid idle", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt_r, cnt_g, cnt_b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_r == 0 && out_g == 0 && out_b == 0, "R10", "reset state",
              {7'd0, out_valid, out_r, out_g, out_b}, 32'd0);
        rst_n = 1'b1;

        // R1: pass-through with dithering off
        send(1, 1, 0, 0, 8'hA7, 8'h13, 8'hFF, "R1");
        send(1, 0, 0, 0, 8'h02, 8'h81, 8'h7E, "R1");
        // R4: saturation at full scale over all four positions
        send(1, 0, 1, 1, 8'hFF, 8'hFF, 8'hFF, "R4");
        send(1, 0, 0, 1, 8'hFF, 8'hFE, 8'hFD, "R4");
        send(1, 0, 1, 1, 8'hFF, 8'hFF, 8'hFF, "R4");
        send(1, 0, 0, 1, 8'hFF, 8'hFF, 8'hFF, "R4");
        // R5: zero fraction never rounds
        send(1, 0, 0, 1, 8'h40, 8'h00, 8'hFC, "R5");
        // R9: markers with valid low are ignored, then next pixel continues the line
        send(0, 1, 1, 1, 8'h11, 8'h22, 8'h33, "R9");
        send(1, 0, 0, 1, 8'h43, 8'h42, 8'h41, "R9");
        send(1, 0, 0, 1, 8'h43, 8'h42, 8'h41, "R9");

        // R7: fixed pixel at (0,0) over four frames rounds up f times
        for (int f = 0; f < 4; f++) begin
            cnt_r = 0; cnt_g = 0; cnt_b = 0;
            for (int fr = 0; fr < 4; fr++) begin
                send(1, 1, 0, 1, {6'd20, 2'(f)}, {6'd30, 2'(f)}, {6'd40, 2'(f)}, "R7");
                if (out_r[7:2] == 6'd21) cnt_r++;
                if (out_g[7:2] == 6'd31) cnt_g++;
                if (out_b[7:2] == 6'd41) cnt_b++;
                send(1, 0, 0, 1, 8'h55, 8'h66, 8'h77, "R6");
            end
            check(cnt_r == f && cnt_g == f && cnt_b == f, "R7", "round-up count",
                  {8'd0, 8'(cnt_r), 8'(cnt_g), 8'(cnt_b)}, {8'd0, 8'(f), 8'(f), 8'(f)});
        end

        // R6, R8: structured frames of 4x4 pixels, random data
        for (int fr = 0; fr < 6; fr++)
            for (int y = 0; y < 4; y++)
                for (int x = 0; x < 4; x++)
                    send(1, (x == 0 && y == 0), (x == 0 && y != 0), 1,
                         8'($urandom), 8'($urandom), 8'($urandom), "R6/R8");

        // R1..R10: constrained random mix of valid gaps, markers and enable
        for (int k = 0; k < 3000; k++) begin
            logic v, s, l, e;
            v = ($urandom % 4) != 0;
            s = ($urandom % 40) == 0;
            l = ($urandom % 8) == 0;
            e = ($urandom % 5) != 0;
            send(v, s, l, e, 8'($urandom), 8'($urandom), 8'($urandom), "R2/R3/R6");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule